// File: doc/BRIEF.md
# Stereo Zero-Cross Volume Update Controller

This block decides when a stereo pair of gain stages picks up a new volume code. Software writes new codes into registers that feed `vol_l_i` and `vol_r_i`. These codes stay inert until an update strobe arrives on either channel's strobe input. At that point, both channels take the new code together. With zero-cross gating off, both channels change on the next cycle. With gating on, each channel waits for its own signal to cross zero, so the gain step lands where it cannot be heard as a click.

A second path covers a signal that never crosses zero. A free-running external timer supplies a tick, and the block forces any pending code through on the second tick after the request. As a result, the forced change always lands between one and two timer periods after the strobe. Mute is a separate control that silences a stage without touching its volume code.

Audio samples arrive as one stereo frame per valid beat. The sample port has a valid/ready pair, but the block never applies back-pressure: `smp_ready_o` is high whenever the block is out of reset. A beat is consumed on any cycle where `smp_valid_i` is high. Sample values on cycles with valid low are ignored.

Top module: `zcv_top`

## Requirements
- R1: Reset state. While reset is asserted and on the first cycle after it, both volume outputs equal the parameter `RST_VOL` (default 16), both mute outputs are 0, and `smp_ready_o` is 1 once reset is released.
- R2: Changing `vol_l_i` or `vol_r_i` has no effect on the volume outputs unless an update strobe is high.
- R3: A strobe on either `upd_l_i` or `upd_r_i` while `zc_en_i` is 0 loads both volume inputs into both outputs. The new values are visible one clock later.
- R4: A strobe while `zc_en_i` is 1 captures both volume inputs as pending targets. Each channel applies its target one clock after its zero crossing. A zero crossing is a valid sample whose most significant (sign) bit differs from that of the channel's previous valid sample, or a valid sample equal to zero. The stored previous sign resets to 0 (non-negative).
- R5: A zero crossing on one channel applies only that channel's pending target and clears only that channel's pending state.
- R6: A code still pending is forced through on the `FORCE_TICKS`-th (default second) `tick_i` pulse after the strobe, and appears one clock later. A tick in the same cycle as the strobe is not counted.
- R7: A strobe while a change is still pending replaces both targets and restarts the tick count. A strobe takes precedence over a crossing or a forced update in the same cycle.
- R8: `mute_l_o` and `mute_r_o` follow `mute_l_i` and `mute_r_i` one clock later. The mute controls never alter the volume outputs.
- R9: Sample beats with `smp_valid_i` low do not count as crossings and do not change the stored sign. `smp_ready_o` stays 1 out of reset.
- R10: `zc_en_i` is sampled only in the strobe cycle. Changing it while a code is pending does not apply that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vol_l_i | input | VW | Written left volume code |
| vol_r_i | input | VW | Written right volume code |
| mute_l_i | input | 1 | Left mute control |
| mute_r_i | input | 1 | Right mute control |
| upd_l_i | input | 1 | Update strobe written via the left channel |
| upd_r_i | input | 1 | Update strobe written via the right channel |
| zc_en_i | input | 1 | 1 = wait for zero crossing, 0 = apply at once |
| tick_i | input | 1 | One-cycle pulse from the free-running timeout timer |
| smp_valid_i | input | 1 | Stereo sample beat valid |
| smp_ready_o | output | 1 | Sample beat accepted (always 1 out of reset) |
| smp_l_i | input | SW | Left signed sample |
| smp_r_i | input | SW | Right signed sample |
| vol_l_o | output | VW | Active left volume code |
| vol_r_o | output | VW | Active right volume code |
| mute_l_o | output | 1 | Active left mute |
| mute_r_o | output | 1 | Active right mute |

## Verification
Several rules are checked on every cycle:
- an output holds when nothing is pending and no strobe arrives;
- an immediate update lands one cycle after the strobe;
- a crossing on a pending channel loads that channel's captured target and clears its pending state;
- a forced update clears all pending state;
- mute follows its input one cycle late.

Other behaviours only show in the bench's scenarios, because they depend on the history of sample signs and tick counts. These are: a valid-low beat not counting as a crossing, the exact tick on which a pending code is forced, the count restarting on a second strobe, and `zc_en_i` being ignored after the strobe. A long randomised mix of strobes, ticks and samples then exercises all of these rules together.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  localparam int NCH  = 2;
  localparam int CH_L = 0;
  localparam int CH_R = 1;

  // A crossing: sign differs from previous sample, or sample is exactly zero.
  function automatic logic crossed(input logic prev_neg, input logic now_neg,
                                   input logic now_zero);
    return now_zero || (prev_neg != now_neg);
  endfunction
endpackage

// File: rtl/zcv_zc_det.sv
module zcv_zc_det #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [SW-1:0] smp_i,
  output logic          zc_o
);
  import zcv_pkg::*;

  logic prev_neg_q;
  logic now_neg;
  logic now_zero;

  assign now_neg  = smp_i[SW-1];
  assign now_zero = (smp_i == '0);
  assign zc_o     = valid_i && crossed(prev_neg_q, now_neg, now_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_neg_q <= 1'b0;
    else if (valid_i) prev_neg_q <= now_neg;
  end
endmodule

// File: rtl/zcv_force_timer.sv
module zcv_force_timer #(
  parameter int FORCE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic armed_i,
  input  logic tick_i,
  output logic force_o
);
  localparam int CW = $clog2(FORCE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(FORCE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign force_o = armed_i && tick_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (restart_i || !armed_i || force_o) cnt_q <= '0;
    else if (tick_i)                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/zcv_chan.sv
module zcv_chan #(
  parameter int VW      = 6,
  parameter int RST_VOL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          imm_i,
  input  logic [VW-1:0] vol_i,
  input  logic          zc_i,
  input  logic          force_i,
  output logic [VW-1:0] vol_o,
  output logic [VW-1:0] tgt_o,
  output logic          pend_o
);
  localparam logic [VW-1:0] RV = VW'(RST_VOL);

  logic [VW-1:0] vol_q;
  logic [VW-1:0] tgt_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q  <= RV;
      tgt_q  <= RV;
      pend_q <= 1'b0;
    end else if (req_i) begin
      tgt_q <= vol_i;
      if (imm_i) begin
        vol_q  <= vol_i;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
      end
    end else if (pend_q && (zc_i || force_i)) begin
      vol_q  <= tgt_q;
      pend_q <= 1'b0;
    end
  end

  assign vol_o  = vol_q;
  assign tgt_o  = tgt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/zcv_top.sv
module zcv_top #(
  parameter int VW          = 6,
  parameter int SW          = 16,
  parameter int RST_VOL     = 16,
  parameter int FORCE_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vol_l_i,
  input  logic [VW-1:0] vol_r_i,
  input  logic          mute_l_i,
  input  logic          mute_r_i,
  input  logic          upd_l_i,
  input  logic          upd_r_i,
  input  logic          zc_en_i,
  input  logic          tick_i,
  input  logic          smp_valid_i,
  output logic          smp_ready_o,
  input  logic [SW-1:0] smp_l_i,
  input  logic [SW-1:0] smp_r_i,
  output logic [VW-1:0] vol_l_o,
  output logic [VW-1:0] vol_r_o,
  output logic          mute_l_o,
  output logic          mute_r_o
);
  import zcv_pkg::*;

  logic                   upd;
  logic                   force_w;
  logic [NCH-1:0]         zc;
  logic [NCH-1:0]         pend;
  logic [NCH-1:0]         mute_q;
  logic [NCH-1:0][VW-1:0] vin;
  logic [NCH-1:0][VW-1:0] act;
  logic [NCH-1:0][VW-1:0] tgt;
  logic [NCH-1:0][SW-1:0] smp;
  logic [NCH-1:0]         mute_in;
  logic                   ready_q;

  assign upd         = upd_l_i | upd_r_i;
  assign vin[CH_L]   = vol_l_i;
  assign vin[CH_R]   = vol_r_i;
  assign smp[CH_L]   = smp_l_i;
  assign smp[CH_R]   = smp_r_i;
  assign mute_in[CH_L] = mute_l_i;
  assign mute_in[CH_R] = mute_r_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zcv_zc_det #(.SW(SW)) u_zc (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (smp_valid_i),
      .smp_i   (smp[c]),
      .zc_o    (zc[c])
    );

    zcv_chan #(.VW(VW), .RST_VOL(RST_VOL)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (upd),
      .imm_i   (!zc_en_i),
      .vol_i   (vin[c]),
      .zc_i    (zc[c]),
      .force_i (force_w),
      .vol_o   (act[c]),
      .tgt_o   (tgt[c]),
      .pend_o  (pend[c])
    );
  end

  zcv_force_timer #(.FORCE_TICKS(FORCE_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (upd),
    .armed_i   (|pend),
    .tick_i    (tick_i),
    .force_o   (force_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      mute_q  <= mute_in;
      ready_q <= 1'b1;
    end
  end

  assign vol_l_o     = act[CH_L];
  assign vol_r_o     = act[CH_R];
  assign mute_l_o    = mute_q[CH_L];
  assign mute_r_o    = mute_q[CH_R];
  assign smp_ready_o = ready_q;
endmodule

// File: rtl/zcv_checker.sv
module zcv_checker #(
  parameter int VW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd,
  input logic          zc_en_i,
  input logic [VW-1:0] vol_l_i,
  input logic [VW-1:0] vol_r_i,
  input logic [VW-1:0] vol_l_o,
  input logic [VW-1:0] vol_r_o,
  input logic [VW-1:0] tgt_l,
  input logic [VW-1:0] tgt_r,
  input logic [1:0]    pend,
  input logic [1:0]    zc,
  input logic          force_w,
  input logic          mute_l_i,
  input logic          mute_l_o
);
  // R2: nothing pending and no strobe -> output holds
  a_r2_hold_l: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !pend[0]) |=> $stable(vol_l_o));
  a_r2_hold_r: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !pend[1]) |=> $stable(vol_r_o));

  // R3: immediate update one cycle after the strobe
  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !zc_en_i) |=> (vol_l_o == $past(vol_l_i)) && (vol_r_o == $past(vol_r_i)));

  // R4 / R5: a crossing applies that channel's captured target only
  a_r4_zc_apply_l: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && zc[0] && !upd) |=> (!pend[0] && vol_l_o == $past(tgt_l)));
  a_r5_zc_apply_r: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && zc[1] && !upd) |=> (!pend[1] && vol_r_o == $past(tgt_r)));

  // R6: a forced update clears all pending state
  a_r6_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (force_w && !upd) |=> (pend == 2'b00));

  // R8: mute follows its input one cycle late
  a_r8_mute_on: assert property (@(posedge clk) disable iff (!rst_n)
    mute_l_i |=> mute_l_o);
  a_r8_mute_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_l_i |=> !mute_l_o);
endmodule

bind zcv_top zcv_checker #(.VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd      (upd),
  .zc_en_i  (zc_en_i),
  .vol_l_i  (vol_l_i),
  .vol_r_i  (vol_r_i),
  .vol_l_o  (vol_l_o),
  .vol_r_o  (vol_r_o),
  .tgt_l    (tgt[0]),
  .tgt_r    (tgt[1]),
  .pend     (pend),
  .zc       (zc),
  .force_w  (force_w),
  .mute_l_i (mute_l_i),
  .mute_l_o (mute_l_o)
);

// File: tb/tb_zcv_top.sv
module tb_zcv_top;
  localparam int CLK_PER = 10;
  localparam int VW = 6;
  localparam int SW = 16;
  localparam int MAX_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] vol_l_i = '0, vol_r_i = '0;
  logic          mute_l_i = 0, mute_r_i = 0, upd_l_i = 0, upd_r_i = 0;
  logic          zc_en_i = 0, tick_i = 0, smp_valid_i = 0;
  logic [SW-1:0] smp_l_i = '0, smp_r_i = '0;
  logic          smp_ready_o, mute_l_o, mute_r_o;
  logic [VW-1:0] vol_l_o, vol_r_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  zcv_top dut (
    .clk(clk), .rst_n(rst_n), .vol_l_i(vol_l_i), .vol_r_i(vol_r_i),
    .mute_l_i(mute_l_i), .mute_r_i(mute_r_i), .upd_l_i(upd_l_i), .upd_r_i(upd_r_i),
    .zc_en_i(zc_en_i), .tick_i(tick_i), .smp_valid_i(smp_valid_i),
    .smp_ready_o(smp_ready_o), .smp_l_i(smp_l_i), .smp_r_i(smp_r_i),
    .vol_l_o(vol_l_o), .vol_r_o(vol_r_o), .mute_l_o(mute_l_o), .mute_r_o(mute_r_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  // Behavioural reference model
  int m_act[2], m_tgt[2], m_pend[2], m_neg[2], m_mute[2], m_cnt, m_rdy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_act[c] = 16; m_tgt[c] = 16; m_pend[c] = 0; m_neg[c] = 0; m_mute[c] = 0;
      end
      m_cnt = 0; m_rdy = 0;
    end else begin
      bit u, anyp, frc;
      int zcs[2], vin[2];
      logic [SW-1:0] s;
      u    = upd_l_i || upd_r_i;
      anyp = (m_pend[0] != 0) || (m_pend[1] != 0);
      frc  = anyp && tick_i && !u && (m_cnt == 1);
      vin[0] = int'(vol_l_i); vin[1] = int'(vol_r_i);
      for (int c = 0; c < 2; c++) begin
        s = (c == 0) ? smp_l_i : smp_r_i;
        zcs[c] = (smp_valid_i && ((s == 0) || (int'(s[SW-1]) != m_neg[c]))) ? 1 : 0;
        if (smp_valid_i) m_neg[c] = int'(s[SW-1]);
      end
      for (int c = 0; c < 2; c++) begin
        if (u) begin
          m_tgt[c] = vin[c];
          if (!zc_en_i) begin m_act[c] = vin[c]; m_pend[c] = 0; end
          else m_pend[c] = 1;
        end else if (m_pend[c] != 0 && (zcs[c] != 0 || frc)) begin
          m_act[c] = m_tgt[c]; m_pend[c] = 0;
        end
      end
      if (u || !anyp || frc) m_cnt = 0;
      else if (tick_i) m_cnt = m_cnt + 1;
      m_mute[0] = int'(mute_l_i); m_mute[1] = int'(mute_r_i);
      m_rdy = 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "vol_l_o", int'(vol_l_o), m_act[0]);
      chk(cur_req, "vol_r_o", int'(vol_r_o), m_act[1]);
      chk(cur_req, "mute_l_o", int'(mute_l_o), m_mute[0]);
      chk(cur_req, "mute_r_o", int'(mute_r_o), m_mute[1]);
      chk(cur_req, "smp_ready_o", int'(smp_ready_o), m_rdy);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_upd(input bit left);
    if (left) upd_l_i = 1; else upd_r_i = 1;
    step();
    upd_l_i = 0; upd_r_i = 0;
  endtask

  task automatic pulse_tick();
    tick_i = 1; step(); tick_i = 0;
  endtask

  task automatic beat(input int l, input int r, input bit v = 1);
    smp_l_i = SW'(l); smp_r_i = SW'(r); smp_valid_i = v;
    step();
    smp_valid_i = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    cur_req = "R1";
    chk("R1", "reset vol_l", int'(vol_l_o), 16);
    chk("R1", "reset mute_r", int'(mute_r_o), 0);
    rst_n = 1;
    step();
    chk("R1", "ready after reset", int'(smp_ready_o), 1);
    chk("R1", "vol_r after reset", int'(vol_r_o), 16);

    cur_req = "R2";
    vol_l_i = 5; vol_r_i = 7;
    step(4);
    chk("R2", "no strobe left", int'(vol_l_o), 16);

    cur_req = "R3";
    pulse_upd(0);
    chk("R3", "immediate left", int'(vol_l_o), 5);
    chk("R3", "immediate right", int'(vol_r_o), 7);

    cur_req = "R4";
    zc_en_i = 1; vol_l_i = 20; vol_r_i = 30;
    pulse_upd(1);
    chk("R4", "held until crossing", int'(vol_l_o), 5);
    beat(100, 50);
    chk("R4", "no sign change", int'(vol_l_o), 5);
    cur_req = "R5";
    beat(-3, 60);
    chk("R5", "left applies", int'(vol_l_o), 20);
    chk("R5", "right still held", int'(vol_r_o), 7);
    beat(-4, 0);
    chk("R4", "zero sample crossing", int'(vol_r_o), 30);

    cur_req = "R9";
    vol_l_i = 40; vol_r_i = 41;
    pulse_upd(0);
    beat(10, -10, 0);
    chk("R9", "invalid beat ignored left", int'(vol_l_o), 20);
    chk("R9", "invalid beat ignored right", int'(vol_r_o), 30);

    cur_req = "R6";
    pulse_tick();
    step(2);
    chk("R6", "first tick no force", int'(vol_l_o), 20);
    pulse_tick();
    chk("R6", "second tick forces left", int'(vol_l_o), 40);
    chk("R6", "second tick forces right", int'(vol_r_o), 41);

    cur_req = "R7";
    vol_l_i = 10; vol_r_i = 11;
    pulse_upd(0);
    pulse_tick();
    vol_l_i = 12; vol_r_i = 13;
    pulse_upd(1);
    pulse_tick();
    chk("R7", "restart holds", int'(vol_l_o), 40);
    pulse_tick();
    chk("R7", "replaced target", int'(vol_l_o), 12);
    chk("R7", "replaced target right", int'(vol_r_o), 13);

    cur_req = "R10";
    vol_l_i = 3; vol_r_i = 4;
    pulse_upd(0);
    zc_en_i = 0;
    step(3);
    chk("R10", "late zc_en ignored", int'(vol_l_o), 12);
    pulse_tick(); pulse_tick();
    chk("R10", "forced after ticks", int'(vol_r_o), 4);

    cur_req = "R8";
    mute_l_i = 1;
    step();
    chk("R8", "mute on", int'(mute_l_o), 1);
    chk("R8", "volume untouched", int'(vol_l_o), 3);
    mute_l_i = 0;
    step();
    chk("R8", "mute off", int'(mute_l_o), 0);

    cur_req = "R7 random mix";
    for (int i = 0; i < 4000; i++) begin
      upd_l_i     = ($urandom_range(0, 19) == 0);
      upd_r_i     = ($urandom_range(0, 39) == 0);
      tick_i      = ($urandom_range(0, 14) == 0);
      smp_valid_i = $urandom_range(0, 1);
      zc_en_i     = ($urandom_range(0, 3) != 0);
      mute_l_i    = $urandom_range(0, 1);
      mute_r_i    = $urandom_range(0, 1);
      vol_l_i     = VW'($urandom);
      vol_r_i     = VW'($urandom);
      smp_l_i     = SW'($urandom_range(0, 6) - 3);
      smp_r_i     = SW'($urandom_range(0, 20) - 10);
      step();
    end
    upd_l_i = 0; upd_r_i = 0; tick_i = 0; smp_valid_i = 0;
    step(2);
    finish_run();
  end
endmodule